// File: doc/BRIEF.md
# Audio Sample FIFO Status Logic

This block sits between a stereo codec's converters and its two sample FIFOs and builds the host-visible test and status byte. On every sample-rate tick it offers one stereo capture word to the capture FIFO and takes one word from the playback FIFO. When the capture FIFO cannot accept the word, the new word is lost and the word already buffered is kept. When the playback FIFO has nothing to give, a substitute value goes to the DAC. Both events raise sticky flags. The host clears them with a read-clear strobe.

The status byte also shows four more things. The first is a calibration-busy flag, which stays high for a fixed number of sample periods after a mode change ends. The second is the OR of the two data-request lines. The last two are a 2-bit overrange code for each capture channel, refreshed on every tick.

Both sample streams use valid/ready, but neither can apply back-pressure to the converter clock. On the capture side, `cap_wr_valid` pulses with each tick. If `cap_wr_ready` is low in that cycle, the word is dropped and never retried. On the playback side, `pb_rd_ready` pulses with each tick. If `pb_rd_valid` is low in that cycle, no word is taken and the slot is an underrun.

Top module: `afs_status`

## Requirements
- R1: On a cycle with `sample_tick` high and `cap_wr_ready` low, the capture-overrun flag (stat bit 7) is set from the next cycle. `cap_wr_valid` equals `sample_tick`, and `cap_wr_data` is {left, right}, so the FIFO keeps its contents and the new word is dropped.
- R2: On a cycle with `sample_tick` high and `pb_rd_valid` low, the playback-underrun flag (stat bit 6) is set from the next cycle. `pb_rd_ready` equals `sample_tick`.
- R3: Both flags are sticky. A `stat_clr` pulse clears them on the next cycle. If a new event arrives in the same cycle as the clear, that flag stays set.
- R4: `dac_out` changes only on a tick, one cycle later. If `pb_rd_valid` is high it takes `pb_rd_data`. On underrun it takes midscale when `dac_zero` or `basic_mode` is high; otherwise it holds its previous value.
- R5: Midscale is 0x0000 when `fmt8` is 0 (16-bit two's complement) and 0x0080 when `fmt8` is 1 (8-bit unsigned).
- R6: `sou` equals stat bit 7 OR stat bit 6.
- R7: Stat bit 5 is high while `cal_run` is high. It is also high from the cycle after `mce` falls until 128 further ticks have occurred; a later fall of `mce` restarts the 128-tick count.
- R8: Stat bit 4 equals `cap_drq` OR `pb_drq`, with no delay.
- R9: On each tick, each channel's overrange code is updated from that tick's input and shows one cycle later. The left code is stat bits 1:0 and the right code is stat bits 3:2. The code values are: 11 if the channel's saturation input is high; otherwise 10 if the magnitude is 32767 or more; otherwise 01 if the magnitude is 29204 or more; otherwise 00.
- R10: After reset `stat` is 0x00 and `dac_out` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle strobe per sample period |
| cap_l | input | 16 | Left capture sample |
| cap_r | input | 16 | Right capture sample |
| sat_l | input | 1 | Left upstream saturation flag |
| sat_r | input | 1 | Right upstream saturation flag |
| cap_wr_valid | output | 1 | Capture word offered to FIFO |
| cap_wr_ready | input | 1 | Capture FIFO can accept (not full) |
| cap_wr_data | output | 32 | Capture word {left, right} |
| pb_rd_valid | input | 1 | Playback FIFO has a word (not empty) |
| pb_rd_data | input | 16 | Playback FIFO head word |
| pb_rd_ready | output | 1 | Pop playback FIFO |
| dac_out | output | 16 | Value sent to the DAC |
| dac_zero | input | 1 | Underrun sends midscale instead of holding |
| basic_mode | input | 1 | Basic mode: underrun always sends midscale |
| fmt8 | input | 1 | 8-bit unsigned sample format |
| cal_run | input | 1 | Calibration running |
| mce | input | 1 | Mode-change enable |
| cap_drq | input | 1 | Capture data-request line |
| pb_drq | input | 1 | Playback data-request line |
| stat_clr | input | 1 | Host read-clear strobe for the sticky flags |
| stat | output | 8 | Status byte |
| sou | output | 1 | Combined overrun/underrun status |

## Verification
The hardest cases to reach are the end of the 128-tick busy window and an overrun or underrun that lands in the same cycle as a read-clear. The window only closes after a long run of ticks with no new fall of the mode-change input. The bench therefore holds `mce` low and ticks every cycle through the whole window. It then switches to a long random phase, where clears, ticks, ready/valid drops and `mce` toggles fall on each other by chance. Magnitude values are drawn near 29204 and 32767, and the value -32768 is included, to hit both overrange thresholds.

// File: rtl/afs_pkg.sv
package afs_pkg;
  typedef logic [1:0] orng_t;

  typedef struct packed {
    logic  cap_ovr;
    logic  pb_und;
    logic  busy;
    logic  drq;
    orng_t orng_r;
    orng_t orng_l;
  } afs_stat_t;
endpackage

// File: rtl/afs_ovr_class.sv
module afs_ovr_class #(
  parameter int W = 16,
  parameter logic [W-1:0] NEAR_MAG = 16'd29204,
  parameter logic [W-1:0] FULL_MAG = 16'd32767
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [W-1:0]    sample,
  input  logic            sat,
  output afs_pkg::orng_t  code
);
  logic [W:0] mag;
  afs_pkg::orng_t nxt;

  always_comb begin
    mag = sample[W-1] ? ({1'b0, ~sample} + 1'b1) : {1'b0, sample};
    if (sat)                         nxt = 2'b11;
    else if (mag >= {1'b0, FULL_MAG}) nxt = 2'b10;
    else if (mag >= {1'b0, NEAR_MAG}) nxt = 2'b01;
    else                             nxt = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code <= 2'b00;
    else if (tick) code <= nxt;
  end

  // R9
  sat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sat) |=> code == 2'b11);
  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(code));
endmodule

// File: rtl/afs_xrun_flags.sv
module afs_xrun_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cap_ready,
  input  logic pb_valid,
  input  logic clr,
  output logic cap_ovr,
  output logic pb_und
);
  logic ovr_ev, und_ev;
  assign ovr_ev = tick & ~cap_ready;
  assign und_ev = tick & ~pb_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ovr <= 1'b0;
      pb_und  <= 1'b0;
    end else begin
      if (ovr_ev)   cap_ovr <= 1'b1;
      else if (clr) cap_ovr <= 1'b0;
      if (und_ev)   pb_und  <= 1'b1;
      else if (clr) pb_und  <= 1'b0;
    end
  end

  // R1
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cap_ready) |=> cap_ovr);
  // R2
  und_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pb_valid) |=> pb_und);
  // R3
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ovr && !clr) |=> cap_ovr);
  // R3
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(tick && !cap_ready)) |=> !cap_ovr);
endmodule

// File: rtl/afs_busy_timer.sv
module afs_busy_timer #(
  parameter int TICKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mce,
  input  logic cal_run,
  output logic busy
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic          mce_q;
  logic [CW-1:0] cnt;
  logic          fall;

  assign fall = mce_q & ~mce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mce_q <= 1'b0;
      cnt   <= '0;
    end else begin
      mce_q <= mce;
      if (fall)                  cnt <= LOAD;
      else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  assign busy = cal_run | (cnt != '0);

  // R7
  busy_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> busy);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD);
  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !fall) |=> $stable(cnt));
endmodule

// File: rtl/afs_dac_sel.sv
module afs_dac_sel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pb_valid,
  input  logic [W-1:0] pb_data,
  input  logic         dac_zero,
  input  logic         basic_mode,
  input  logic         fmt8,
  output logic [W-1:0] dac_out
);
  localparam logic [W-1:0] MID8  = {{(W-8){1'b0}}, 8'h80};
  localparam logic [W-1:0] MID16 = '0;

  logic [W-1:0] mid;
  logic         force_mid;

  assign mid       = fmt8 ? MID8 : MID16;
  assign force_mid = dac_zero | basic_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_out <= '0;
    else if (tick) begin
      if (pb_valid)       dac_out <= pb_data;
      else if (force_mid) dac_out <= mid;
    end
  end

  // R4
  dac_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pb_valid) |=> dac_out == $past(pb_data));
  // R5
  dac_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pb_valid && (dac_zero || basic_mode)) |=>
      dac_out == ($past(fmt8) ? MID8 : MID16));
  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dac_out));
endmodule

// File: rtl/afs_status.sv
module afs_status #(
  parameter int W = 16,
  parameter int BUSY_TICKS = 128,
  parameter logic [W-1:0] NEAR_MAG = 16'd29204,
  parameter logic [W-1:0] FULL_MAG = 16'd32767
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_tick,
  input  logic [W-1:0]   cap_l,
  input  logic [W-1:0]   cap_r,
  input  logic           sat_l,
  input  logic           sat_r,
  output logic           cap_wr_valid,
  input  logic           cap_wr_ready,
  output logic [2*W-1:0] cap_wr_data,
  input  logic           pb_rd_valid,
  input  logic [W-1:0]   pb_rd_data,
  output logic           pb_rd_ready,
  output logic [W-1:0]   dac_out,
  input  logic           dac_zero,
  input  logic           basic_mode,
  input  logic           fmt8,
  input  logic           cal_run,
  input  logic           mce,
  input  logic           cap_drq,
  input  logic           pb_drq,
  input  logic           stat_clr,
  output logic [7:0]     stat,
  output logic           sou
);
  import afs_pkg::*;

  afs_stat_t s;
  logic [W-1:0] ch_smp [2];
  logic         ch_sat [2];
  orng_t        ch_code [2];

  assign ch_smp[0] = cap_l;
  assign ch_smp[1] = cap_r;
  assign ch_sat[0] = sat_l;
  assign ch_sat[1] = sat_r;

  assign cap_wr_valid = sample_tick;
  assign cap_wr_data  = {cap_l, cap_r};
  assign pb_rd_ready  = sample_tick;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    afs_ovr_class #(.W(W), .NEAR_MAG(NEAR_MAG), .FULL_MAG(FULL_MAG)) u_cls (
      .clk(clk), .rst_n(rst_n), .tick(sample_tick),
      .sample(ch_smp[c]), .sat(ch_sat[c]), .code(ch_code[c]));
  end

  afs_xrun_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick),
    .cap_ready(cap_wr_ready), .pb_valid(pb_rd_valid), .clr(stat_clr),
    .cap_ovr(s.cap_ovr), .pb_und(s.pb_und));

  afs_busy_timer #(.TICKS(BUSY_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick),
    .mce(mce), .cal_run(cal_run), .busy(s.busy));

  afs_dac_sel #(.W(W)) u_dac (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick),
    .pb_valid(pb_rd_valid), .pb_data(pb_rd_data),
    .dac_zero(dac_zero), .basic_mode(basic_mode), .fmt8(fmt8),
    .dac_out(dac_out));

  assign s.drq    = cap_drq | pb_drq;
  assign s.orng_l = ch_code[0];
  assign s.orng_r = ch_code[1];
  assign stat     = s;
  assign sou      = s.cap_ovr | s.pb_und;

  // R6
  sou_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && sample_tick && cap_wr_ready && pb_rd_valid) |=> !sou);
endmodule

// File: tb/tb_afs_status.sv
module tb_afs_status;
  logic clk = 0, rst_n = 0;
  logic sample_tick = 0, sat_l = 0, sat_r = 0;
  logic [15:0] cap_l = 0, cap_r = 0, pb_rd_data = 0;
  logic cap_wr_ready = 1, pb_rd_valid = 1;
  logic dac_zero = 0, basic_mode = 0, fmt8 = 0, cal_run = 0, mce = 0;
  logic cap_drq = 0, pb_drq = 0, stat_clr = 0;
  logic cap_wr_valid, pb_rd_ready, sou;
  logic [31:0] cap_wr_data;
  logic [15:0] dac_out;
  logic [7:0] stat;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  afs_status dut (.*);

  // behavioural reference state
  bit m_ovr, m_und, m_mce;
  int m_left;
  int m_dac;
  int m_ol, m_or;

  function automatic int classify(logic [15:0] v, logic sat);
    int mag;
    mag = $signed(v);
    if (mag < 0) mag = -mag;
    if (sat) return 3;
    if (mag >= 32767) return 2;
    if (mag >= 29204) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ovr = 0; m_und = 0; m_mce = 0; m_left = 0; m_dac = 0; m_ol = 0; m_or = 0;
    end else begin
      if (sample_tick && !cap_wr_ready) m_ovr = 1; else if (stat_clr) m_ovr = 0;
      if (sample_tick && !pb_rd_valid) m_und = 1; else if (stat_clr) m_und = 0;
      if (m_mce && !mce) m_left = 128;
      else if (sample_tick && m_left > 0) m_left--;
      m_mce = mce;
      if (sample_tick) begin
        if (pb_rd_valid) m_dac = pb_rd_data;
        else if (dac_zero || basic_mode) m_dac = fmt8 ? 'h80 : 0;
        m_ol = classify(cap_l, sat_l);
        m_or = classify(cap_r, sat_r);
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 overrun flag", stat[7], m_ovr);
    chk("R2 underrun flag", stat[6], m_und);
    chk("R7 busy", stat[5], cal_run || m_left > 0);
    chk("R8 drq", stat[4], cap_drq || pb_drq);
    chk("R9 right overrange", stat[3:2], m_or);
    chk("R9 left overrange", stat[1:0], m_ol);
    chk("R6 sou", sou, m_ovr || m_und);
    chk("R4 R5 dac", dac_out, m_dac);
    chk("R1 capture handshake", {cap_wr_valid, cap_wr_data}, {sample_tick, cap_l, cap_r});
    chk("R2 playback pop", pb_rd_ready, sample_tick);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic tick_once(logic [15:0] l, logic [15:0] r, logic crdy, logic pv, logic [15:0] pd);
    sample_tick = 1; cap_l = l; cap_r = r; cap_wr_ready = crdy; pb_rd_valid = pv; pb_rd_data = pd;
    step();
    sample_tick = 0;
    step();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset stat", stat, 8'h00);
    chk("R10 reset dac", dac_out, 16'h0000);
    rst_n = 1;
    step();
    // R4 normal playback
    tick_once(16'h0100, 16'hFF00, 1, 1, 16'h1234);
    // R4 underrun hold
    tick_once(16'h0, 16'h0, 1, 0, 16'hAAAA);
    // R5 midscale 8-bit then 16-bit
    dac_zero = 1; fmt8 = 1;
    tick_once(16'h0, 16'h0, 1, 0, 16'hAAAA);
    fmt8 = 0; tick_once(16'h0, 16'h0, 1, 1, 16'h5555);
    tick_once(16'h0, 16'h0, 1, 0, 16'hAAAA);
    // R4 basic mode forces midscale
    dac_zero = 0; basic_mode = 1; fmt8 = 1;
    tick_once(16'h0, 16'h0, 1, 1, 16'h7777);
    tick_once(16'h0, 16'h0, 1, 0, 16'hAAAA);
    basic_mode = 0; fmt8 = 0;
    // R3 clear, then event in same cycle as clear
    stat_clr = 1; step(); stat_clr = 0; step();
    stat_clr = 1; tick_once(16'h0, 16'h0, 0, 1, 16'h1);
    stat_clr = 0; step();
    // R9 thresholds
    tick_once(16'd29203, 16'd29204, 1, 1, 0);
    tick_once(16'h8000, 16'd32767, 1, 1, 0);
    tick_once(-16'sd29204, -16'sd29203, 1, 1, 0);
    sat_l = 1; tick_once(16'h0, 16'h0, 1, 1, 0); sat_l = 0;
    // R8 drq
    cap_drq = 1; step(); cap_drq = 0; pb_drq = 1; step(); pb_drq = 0; step();
    // R7 full busy window with ticks every cycle
    cal_run = 1; step(); cal_run = 0;
    mce = 1; step(); step(); mce = 0;
    sample_tick = 1;
    for (int i = 0; i < 135; i++) step();
    sample_tick = 0; step();
    // random phase
    for (int i = 0; i < 6000; i++) begin
      sample_tick  = ($urandom % 2) == 0;
      cap_wr_ready = ($urandom % 5) != 0;
      pb_rd_valid  = ($urandom % 5) != 0;
      stat_clr     = ($urandom % 8) == 0;
      dac_zero     = ($urandom % 3) == 0;
      basic_mode   = ($urandom % 6) == 0;
      fmt8         = ($urandom % 2) == 0;
      cal_run      = ($urandom % 20) == 0;
      if (($urandom % 150) == 0) mce = ~mce;
      cap_drq      = ($urandom % 4) == 0;
      pb_drq       = ($urandom % 4) == 0;
      sat_l        = ($urandom % 16) == 0;
      sat_r        = ($urandom % 16) == 0;
      case ($urandom % 4)
        0: cap_l = 16'($urandom);
        1: cap_l = 16'd29200 + 16'($urandom % 8);
        2: cap_l = 16'h8000 + 16'($urandom % 3);
        default: cap_l = 16'd32760 + 16'($urandom % 8);
      endcase
      cap_r      = ($urandom % 2) ? 16'($urandom) : -(16'd29200 + 16'($urandom % 8));
      pb_rd_data = 16'($urandom);
      step();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule